// File: doc/BRIEF.md
# Tiled Surface Pitch Validator

This block decides whether a surface description is legal to place in tiled memory on a given hardware generation. A request carries four things: a row stride in bytes, an object size in bytes, a tiling layout, and a generation code. A fifth input, a capability flag, says whether Y-tiled rows are 128 bytes wide.

The block registers a pass/fail verdict and a reason code. Both appear one clock after the request strobe, together with a one-cycle response strobe. Software or an allocation engine uses the verdict before it commits a tiling change.

Generations 4 and newer only bound the pitch and require the stride to be a whole number of tile rows. Older generations work differently. They cap the stride at a fixed byte count and bound the object size with a limit that depends on the generation. They also require the stride to be a power of two that is no narrower than one tile.

Top module: `pitch_validator`

## Requirements
- R1: Layout code 0 (linear) is accepted with reason 0 for any stride, size and generation.
- R2: The tile width is 128 bytes when the generation code is 2 or below, or when the layout is Y (code 2) and the 128-byte-Y flag is set. Otherwise the tile width is 512 bytes.
- R3: For generation codes 4 and above, a tiled request whose stride shifted right by 7 exceeds MAX_PITCH_UNITS (default 511) fails with reason 1 (stride too large).
- R4: For generation codes 4 and above, a tiled stride that is not a multiple of the tile width fails with reason 3 (misaligned). Any multiple that is within the pitch bound passes, whether or not it is a power of two.
- R5: For generation codes 4 and above, the object size never affects the verdict.
- R6: For generation codes below 4, a tiled stride above 8192 bytes fails with reason 1.
- R7: For generation codes below 4, a tiled object larger than MAX_SIZE_UNITS shifted left by 20 (generation 3) or by 19 (generation 2 and below) fails with reason 2. The default MAX_SIZE_UNITS is 64.
- R8: For generation codes below 4, a tiled stride narrower than the tile width fails with reason 3. A stride that is not a power of two fails with reason 4.
- R9: When several rules fail, the reported reason follows this order: stride too large, then size too large, then misaligned or too narrow, then not a power of two.
- R10: Layout code 3 is reserved. It fails with reason 5 on every generation.
- R11: The response strobe is high exactly in the cycle after a request strobe. The verdict and reason hold until the next request. Reset clears the strobe, the verdict and the reason.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqStride | input | STRIDE_W | Row stride in bytes |
| reqSize | input | SIZE_W | Object size in bytes |
| reqMode | input | 2 | Layout: 0 linear, 1 X, 2 Y, 3 reserved |
| reqGen | input | 4 | Hardware generation code |
| reqShortYTile | input | 1 | Y tiles are 128 bytes wide |
| rspValid | output | 1 | Response strobe |
| rspOk | output | 1 | 1 when the request is legal |
| rspReason | output | 3 | 0 ok, 1 stride too large, 2 size too large, 3 misaligned, 4 not power of two, 5 reserved layout |

## Verification
The clocked properties assume that the request fields are stable only in the cycle that reqValid marks. They compare the verdict against the fields captured one edge earlier. They also assume that the stride is never zero in a legacy tiled request that passes; the narrow-tile rule already rejects a zero stride. The stimulus drives every request for exactly one cycle at the falling edge and returns reqValid low between requests. That keeps each response cycle tied to a single request and never overlapping the next one. The generation codes used are 2, 3, 4 and 6, which cover both rule families and both legacy size shifts.

// File: rtl/pv_pkg.sv
package pv_pkg;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tileMode_e;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_STRIDE_BIG = 3'd1,
    RSN_SIZE_BIG   = 3'd2,
    RSN_MISALIGN   = 3'd3,
    RSN_NOT_POW2   = 3'd4,
    RSN_BAD_MODE   = 3'd5
  } reason_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;
    logic busy;
  } ctrlStrobe_t;

  localparam int unsigned GEN_W = 4;

endpackage

// File: rtl/pv_ctrl.sv
module pv_ctrl
  import pv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output ctrlStrobe_t strobes,
  output logic        rspValid
);

  logic rspValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) rspValidQ <= 1'b0;
    else       rspValidQ <= reqValid;
  end

  always_comb begin
    strobes.capture = reqValid;
    strobes.busy    = rspValidQ;
  end

  assign rspValid = rspValidQ;

  // R11: response strobe follows the request by one cycle
  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_rsp_only_after_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/pv_datapath.sv
module pv_datapath
  import pv_pkg::*;
#(
  parameter int unsigned STRIDE_W          = 32,
  parameter int unsigned SIZE_W            = 32,
  parameter int unsigned MAX_PITCH_UNITS   = 511,
  parameter int unsigned MAX_SIZE_UNITS    = 64,
  parameter int unsigned LEGACY_MAX_STRIDE = 8192,
  parameter int unsigned NARROW_TILE_BYTES = 128,
  parameter int unsigned WIDE_TILE_BYTES   = 512,
  parameter int unsigned PITCH_UNIT_BYTES  = 128,
  parameter int unsigned FIRST_MODERN_GEN  = 4,
  parameter int unsigned OLDEST_GEN        = 2,
  parameter int unsigned SIZE_SHIFT_G3     = 20,
  parameter int unsigned SIZE_SHIFT_OLD    = 19
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobes,
  input  logic [STRIDE_W-1:0] reqStride,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [1:0]          reqMode,
  input  logic [GEN_W-1:0]    reqGen,
  input  logic                reqShortYTile,
  output logic                rspOk,
  output logic [2:0]          rspReason
);

  localparam int unsigned PITCH_SHIFT = $clog2(PITCH_UNIT_BYTES);
  localparam logic [63:0] SIZE_LIMIT_G3  = 64'(MAX_SIZE_UNITS) << SIZE_SHIFT_G3;
  localparam logic [63:0] SIZE_LIMIT_OLD = 64'(MAX_SIZE_UNITS) << SIZE_SHIFT_OLD;
  localparam logic [STRIDE_W-1:0] NARROW_MASK = STRIDE_W'(NARROW_TILE_BYTES - 1);
  localparam logic [STRIDE_W-1:0] WIDE_MASK   = STRIDE_W'(WIDE_TILE_BYTES - 1);
  localparam logic [STRIDE_W-1:0] NARROW_W    = STRIDE_W'(NARROW_TILE_BYTES);
  localparam logic [STRIDE_W-1:0] WIDE_W      = STRIDE_W'(WIDE_TILE_BYTES);
  localparam logic [GEN_W-1:0]    MODERN_GEN  = GEN_W'(FIRST_MODERN_GEN);
  localparam logic [GEN_W-1:0]    OLD_GEN     = GEN_W'(OLDEST_GEN);
  localparam logic [GEN_W-1:0]    GEN3        = GEN_W'(FIRST_MODERN_GEN - 1);

  tileMode_e mode;
  logic isModern;
  logic isOldest;
  logic narrowTile;
  logic [STRIDE_W-1:0] tileMask;
  logic [STRIDE_W-1:0] tileWidth;
  logic [STRIDE_W-1:0] pitchUnits;
  logic [63:0] sizeLimit;
  logic pitchTooBig;
  logic legacyStrideBig;
  logic sizeTooBig;
  logic notMultiple;
  logic tooNarrow;
  logic notPow2;
  reason_e reasonNext;
  reason_e reasonQ;
  logic okQ;

  // Tile geometry selection
  always_comb begin
    mode       = tileMode_e'(reqMode);
    isModern   = (reqGen >= MODERN_GEN);
    isOldest   = (reqGen <= OLD_GEN);
    narrowTile = isOldest || ((mode == TILE_Y) && reqShortYTile);
    tileMask   = narrowTile ? NARROW_MASK : WIDE_MASK;
    tileWidth  = narrowTile ? NARROW_W : WIDE_W;
  end

  // Individual rule checks
  always_comb begin
    pitchUnits      = reqStride >> PITCH_SHIFT;
    pitchTooBig     = (64'(pitchUnits) > 64'(MAX_PITCH_UNITS));
    legacyStrideBig = (64'(reqStride) > 64'(LEGACY_MAX_STRIDE));
    sizeLimit       = (reqGen == GEN3) ? SIZE_LIMIT_G3 : SIZE_LIMIT_OLD;
    sizeTooBig      = (64'(reqSize) > sizeLimit);
    notMultiple     = ((reqStride & tileMask) != '0);
    tooNarrow       = (reqStride < tileWidth);
    notPow2         = ((reqStride & (reqStride - STRIDE_W'(1))) != '0);
  end

  // Verdict with fixed priority
  always_comb begin
    reasonNext = RSN_NONE;
    if (mode == TILE_RSVD) begin
      reasonNext = RSN_BAD_MODE;
    end else if (mode == TILE_LINEAR) begin
      reasonNext = RSN_NONE;
    end else if (isModern) begin
      if (pitchTooBig)      reasonNext = RSN_STRIDE_BIG;
      else if (notMultiple) reasonNext = RSN_MISALIGN;
    end else begin
      if (legacyStrideBig)  reasonNext = RSN_STRIDE_BIG;
      else if (sizeTooBig)  reasonNext = RSN_SIZE_BIG;
      else if (tooNarrow)   reasonNext = RSN_MISALIGN;
      else if (notPow2)     reasonNext = RSN_NOT_POW2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      okQ     <= 1'b0;
      reasonQ <= RSN_NONE;
    end else if (strobes.capture) begin
      okQ     <= (reasonNext == RSN_NONE);
      reasonQ <= reasonNext;
    end
  end

  assign rspOk     = okQ;
  assign rspReason = reasonQ;

  // R1: linear always passes
  p_linear_ok_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqMode == 2'd0) |=> (rspOk && rspReason == 3'd0));

  // R5: modern generations never report a size failure
  p_modern_no_size_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqGen >= MODERN_GEN) |=> (rspReason != 3'd2));

  // R6: a passing legacy tiled stride stays within the byte cap
  p_legacy_stride_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqGen < MODERN_GEN && (reqMode == 2'd1 || reqMode == 2'd2))
    |=> (!rspOk || 64'($past(reqStride)) <= 64'(LEGACY_MAX_STRIDE)));

  // R8: a passing legacy tiled stride is a power of two
  p_legacy_pow2_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqGen < MODERN_GEN && (reqMode == 2'd1 || reqMode == 2'd2))
    |=> (!rspOk || $countones($past(reqStride)) == 1));

  // R10: reserved layout always fails
  p_reserved_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && reqMode == 2'd3) |=> (!rspOk && rspReason == 3'd5));

  // R11: verdict holds while no request arrives
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !strobes.busy) |=> ($stable(rspOk) && $stable(rspReason)));

endmodule

// File: rtl/pitch_validator.sv
module pitch_validator
  import pv_pkg::*;
#(
  parameter int unsigned STRIDE_W        = 32,
  parameter int unsigned SIZE_W          = 32,
  parameter int unsigned MAX_PITCH_UNITS = 511,
  parameter int unsigned MAX_SIZE_UNITS  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [STRIDE_W-1:0] reqStride,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [1:0]          reqMode,
  input  logic [3:0]          reqGen,
  input  logic                reqShortYTile,
  output logic                rspValid,
  output logic                rspOk,
  output logic [2:0]          rspReason
);

  ctrlStrobe_t strobes;

  pv_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  pv_datapath #(
    .STRIDE_W        (STRIDE_W),
    .SIZE_W          (SIZE_W),
    .MAX_PITCH_UNITS (MAX_PITCH_UNITS),
    .MAX_SIZE_UNITS  (MAX_SIZE_UNITS)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .reqStride     (reqStride),
    .reqSize       (reqSize),
    .reqMode       (reqMode),
    .reqGen        (reqGen),
    .reqShortYTile (reqShortYTile),
    .rspOk         (rspOk),
    .rspReason     (rspReason)
  );

endmodule

// File: tb/pitch_validator_tb.sv
`timescale 1ns/1ps
module pitch_validator_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqStride = '0;
  logic [31:0] reqSize = '0;
  logic [1:0]  reqMode = '0;
  logic [3:0]  reqGen = '0;
  logic        reqShortYTile = 1'b0;
  logic        rspValid;
  logic        rspOk;
  logic [2:0]  rspReason;

  int checkCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  pitch_validator dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStride(reqStride),
    .reqSize(reqSize), .reqMode(reqMode), .reqGen(reqGen),
    .reqShortYTile(reqShortYTile), .rspValid(rspValid), .rspOk(rspOk),
    .rspReason(rspReason)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one request for one cycle and check the response one edge later
  task automatic runCase(input string tag, input logic [31:0] s, input logic [31:0] sz,
                         input logic [1:0] m, input logic [3:0] g, input logic f,
                         input logic expOk, input logic [2:0] expReason);
    @(negedge clk);
    reqStride = s; reqSize = sz; reqMode = m; reqGen = g; reqShortYTile = f;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkVal({tag, " valid"}, 32'(rspValid), 32'd1);
    checkVal({tag, " ok"}, 32'(rspOk), 32'(expOk));
    checkVal({tag, " reason"}, 32'(rspReason), 32'(expReason));
  endtask

  task automatic testReset();
    checkVal("R11 reset valid", 32'(rspValid), 32'd0);
    checkVal("R11 reset ok", 32'(rspOk), 32'd0);
    checkVal("R11 reset reason", 32'(rspReason), 32'd0);
  endtask

  task automatic testLinear();
    runCase("R1 linear gen2 odd", 32'd3, 32'hFFFF_FFFF, 2'd0, 4'd2, 1'b0, 1'b1, 3'd0);
    runCase("R1 linear gen6 huge", 32'hFFFF_FFFF, 32'd0, 2'd0, 4'd6, 1'b1, 1'b1, 3'd0);
  endtask

  task automatic testTileWidth();
    runCase("R2 gen2 X 128", 32'd128, 32'd4096, 2'd1, 4'd2, 1'b0, 1'b1, 3'd0);
    runCase("R2 gen3 X 256", 32'd256, 32'd4096, 2'd1, 4'd3, 1'b1, 1'b0, 3'd3);
    runCase("R2 gen3 Y short 256", 32'd256, 32'd4096, 2'd2, 4'd3, 1'b1, 1'b1, 3'd0);
    runCase("R2 gen3 Y wide 256", 32'd256, 32'd4096, 2'd2, 4'd3, 1'b0, 1'b0, 3'd3);
  endtask

  task automatic testModernPitch();
    runCase("R3 gen4 X 65536", 32'd65536, 32'd4096, 2'd1, 4'd4, 1'b0, 1'b0, 3'd1);
    runCase("R3 gen4 X 65024", 32'd65024, 32'd4096, 2'd1, 4'd4, 1'b0, 1'b1, 3'd0);
    runCase("R3 gen4 Y short 65408", 32'd65408, 32'd4096, 2'd2, 4'd4, 1'b1, 1'b1, 3'd0);
  endtask

  task automatic testModernAlign();
    runCase("R4 gen4 X 1536", 32'd1536, 32'd4096, 2'd1, 4'd4, 1'b0, 1'b1, 3'd0);
    runCase("R4 gen4 X 1600", 32'd1600, 32'd4096, 2'd1, 4'd4, 1'b0, 1'b0, 3'd3);
    runCase("R4 gen6 Y short 384", 32'd384, 32'd4096, 2'd2, 4'd6, 1'b1, 1'b1, 3'd0);
  endtask

  task automatic testModernSize();
    runCase("R5 gen6 X huge size", 32'd512, 32'hFFFF_FFFF, 2'd1, 4'd6, 1'b0, 1'b1, 3'd0);
  endtask

  task automatic testLegacyStride();
    runCase("R6 gen3 X 8192", 32'd8192, 32'd4096, 2'd1, 4'd3, 1'b0, 1'b1, 3'd0);
    runCase("R6 gen3 X 16384", 32'd16384, 32'd4096, 2'd1, 4'd3, 1'b0, 1'b0, 3'd1);
  endtask

  task automatic testLegacySize();
    runCase("R7 gen3 at limit", 32'd512, 32'd67108864, 2'd1, 4'd3, 1'b0, 1'b1, 3'd0);
    runCase("R7 gen3 over limit", 32'd512, 32'd67108865, 2'd1, 4'd3, 1'b0, 1'b0, 3'd2);
    runCase("R7 gen2 at limit", 32'd128, 32'd33554432, 2'd1, 4'd2, 1'b0, 1'b1, 3'd0);
    runCase("R7 gen2 over limit", 32'd128, 32'd33554433, 2'd1, 4'd2, 1'b0, 1'b0, 3'd2);
  endtask

  task automatic testLegacyPow2();
    runCase("R8 gen3 X 1536", 32'd1536, 32'd4096, 2'd1, 4'd3, 1'b0, 1'b0, 3'd4);
    runCase("R8 gen2 X 384", 32'd384, 32'd4096, 2'd1, 4'd2, 1'b0, 1'b0, 3'd4);
    runCase("R8 gen2 Y 64", 32'd64, 32'd4096, 2'd2, 4'd2, 1'b0, 1'b0, 3'd3);
  endtask

  task automatic testPriority();
    runCase("R9 stride before size", 32'd12288, 32'hFFFF_FFFF, 2'd1, 4'd3, 1'b0, 1'b0, 3'd1);
    runCase("R9 size before pow2", 32'd1536, 32'hFFFF_FFFF, 2'd1, 4'd3, 1'b0, 1'b0, 3'd2);
    runCase("R9 narrow before pow2", 32'd384, 32'd4096, 2'd1, 4'd3, 1'b0, 1'b0, 3'd3);
  endtask

  task automatic testReserved();
    runCase("R10 gen2 rsvd", 32'd128, 32'd4096, 2'd3, 4'd2, 1'b0, 1'b0, 3'd5);
    runCase("R10 gen6 rsvd", 32'd512, 32'd4096, 2'd3, 4'd6, 1'b0, 1'b0, 3'd5);
  endtask

  task automatic testHold();
    runCase("R11 setup", 32'd1600, 32'd4096, 2'd1, 4'd4, 1'b0, 1'b0, 3'd3);
    // Idle inputs that would pass must not change the held verdict
    reqStride = 32'd512; reqMode = 2'd0;
    @(negedge clk);
    checkVal("R11 strobe drops", 32'(rspValid), 32'd0);
    checkVal("R11 ok held", 32'(rspOk), 32'd0);
    checkVal("R11 reason held", 32'(rspReason), 32'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testTileWidth();
    testModernPitch();
    testModernAlign();
    testModernSize();
    testLegacyStride();
    testLegacySize();
    testLegacyPow2();
    testPriority();
    testReserved();
    testHold();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule